// File: doc/BRIEF.md
# RTC Register Bank Address Decoder

This block is the register-access back end of a serial-bus real-time clock. The serial front end hands it the byte address it has just received. The block answers with an acknowledge decision, then serves a burst of byte reads and writes starting at that address. The block holds a small bank of timekeeping bytes, a set of configuration and alarm bytes, and a 64-byte general-purpose SRAM. Reserved holes inside the clock region read back zero. Addresses above the SRAM are refused at the address byte.

The timekeeping bytes are also reachable from the calendar logic. A flat output bus shows every time byte. A byte-wide update port lets the calendar logic post an incremented value. When a host write and a calendar update land on the same byte in the same cycle, the host write is stored.

Both data directions are single-cycle strobes with no back-pressure, and the block accepts one strobe in every cycle. `dat_valid` marks a transfer, `dat_wr` gives its direction, and a read is answered by `dat_rvalid` exactly one cycle later. If `addr_valid` and `dat_valid` are both high in the same cycle, the address load wins and the data strobe is discarded.

Top module: `rtc_regbank`

## Requirements
- R1: `addr_ack_vld` is high for exactly the one cycle after an `addr_valid` strobe. In that cycle `addr_ack` is 1 when the received address is below 0x60, and 0 for 0x60 through 0xFF.
- R2: Addresses 0x00–0x06 are time bytes 0–6. They are readable and writable and store any written value unchanged, with no range or BCD check. Byte k is visible on `time_bytes[8k+7:8k]` from the cycle after the write.
- R3: Addresses 0x07–0x16 are sixteen configuration and alarm bytes. They are readable and writable, and byte k appears on `ctl_bytes[8k+7:8k]` for address 0x07+k.
- R4: Addresses 0x17–0x1F are reserved. Writes to them change nothing, and reads of them return 0x00.
- R5: Addresses 0x20–0x5F form a 64-byte SRAM. Each location keeps its own written value.
- R6: A read strobe (`dat_valid`=1, `dat_wr`=0, `addr_valid`=0) makes `dat_rvalid` high in the next cycle, with the addressed byte on `dat_rdata`. In every other case `dat_rvalid` is low in the next cycle.
- R7: Each accepted data strobe advances the address pointer by one, so consecutive strobes reach consecutive addresses.
- R8: Once a burst has stepped past 0x5F, the pointer stays at 0x60. Further reads there return 0x00, further writes are dropped, and no acknowledge pulse is produced.
- R9: A calendar update (`tk_upd_valid`, `tk_upd_idx`, `tk_upd_data`) stores its byte into time byte `tk_upd_idx`. If a host write hits that same byte in the same cycle, the host value is stored. If the host write hits a different byte, both values are stored.
- R10: Reset clears every time, configuration, alarm and SRAM byte to 0x00, and clears `dat_rvalid` and `addr_ack_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address byte strobe from the serial front end |
| addr_in | input | 8 | Received byte address |
| addr_ack_vld | output | 1 | Acknowledge decision is valid (one cycle after `addr_valid`) |
| addr_ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| dat_valid | input | 1 | Data byte strobe |
| dat_wr | input | 1 | 1 = write, 0 = read |
| dat_wdata | input | 8 | Write data |
| dat_rvalid | output | 1 | Read data valid |
| dat_rdata | output | 8 | Read data |
| tk_upd_valid | input | 1 | Calendar logic update strobe |
| tk_upd_idx | input | 3 | Time byte index for the update |
| tk_upd_data | input | 8 | Updated time byte value |
| time_bytes | output | 56 | All time bytes, with byte k at bits 8k+7:8k |
| ctl_bytes | output | 128 | Configuration and alarm bytes, with byte k at bits 8k+7:8k |

## Verification
The two functions that can meet in one cycle are a host write to a time byte and a calendar update. The bench provokes this for every time byte. It drives both strobes in the same cycle, once aimed at the same byte and once at a neighbouring byte. In the next cycle it judges `time_bytes`: the host value must win a shared byte, and both values must survive when the targets differ.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;

  typedef enum logic [2:0] {
    RGN_TIME,
    RGN_CTRL,
    RGN_RSVD,
    RGN_SRAM,
    RGN_NONE
  } rgn_e;

  // Classify a byte address against the configured layout.
  function automatic rgn_e rgn_of(input logic [7:0] a, input int tn, input int cn,
                                  input int span, input int sn);
    int ai;
    ai = int'(a);
    if (ai < tn)             return RGN_TIME;
    else if (ai < tn + cn)   return RGN_CTRL;
    else if (ai < span)      return RGN_RSVD;
    else if (ai < span + sn) return RGN_SRAM;
    else                     return RGN_NONE;
  endfunction

endpackage

// File: rtl/rtc_addr_ptr.sv
module rtc_addr_ptr #(
  parameter logic [7:0] LIMIT = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_addr,
  input  logic       step,
  output logic [7:0] ptr,
  output logic       ack_vld,
  output logic       ack
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack_vld <= load;
      if (load) begin
        ptr <= load_addr;
        ack <= (load_addr < LIMIT);
      end else if (step && (ptr < LIMIT)) begin
        ptr <= ptr + 8'd1;
      end
    end
  end

endmodule

// File: rtl/rtc_byte_regs.sv
module rtc_byte_regs #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [7:0]        wdata,
  input  logic              upd_valid,
  input  logic [IW-1:0]     upd_idx,
  input  logic [7:0]        upd_data,
  output logic [N-1:0][7:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_byte
    logic host_hit, upd_hit;
    assign host_hit = we && (idx == IW'(i));
    assign upd_hit  = upd_valid && (upd_idx == IW'(i));

    // Host access takes precedence over a same-cycle update.
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 8'h00;
      else if (host_hit) q[i] <= wdata;
      else if (upd_hit)  q[i] <= upd_data;
    end
  end

endmodule

// File: rtl/rtc_sram.sv
module rtc_sram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [DEPTH-1:0][7:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n)  mem       <= '0;
    else if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
  parameter int TIME_N   = 7,
  parameter int CTL_N    = 16,
  parameter int CLK_SPAN = 32,
  parameter int SRAM_N   = 64,
  localparam int TIW = $clog2(TIME_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  input  logic [7:0]          addr_in,
  output logic                addr_ack_vld,
  output logic                addr_ack,
  input  logic                dat_valid,
  input  logic                dat_wr,
  input  logic [7:0]          dat_wdata,
  output logic                dat_rvalid,
  output logic [7:0]          dat_rdata,
  input  logic                tk_upd_valid,
  input  logic [TIW-1:0]      tk_upd_idx,
  input  logic [7:0]          tk_upd_data,
  output logic [8*TIME_N-1:0] time_bytes,
  output logic [8*CTL_N-1:0]  ctl_bytes
);
  import rtc_regbank_pkg::*;

  localparam int CIW = $clog2(CTL_N);
  localparam int SAW = $clog2(SRAM_N);
  localparam logic [7:0] LIMIT = 8'(CLK_SPAN + SRAM_N);

  logic [7:0]              ptr;
  logic                    stb, wr_stb, rd_stb;
  rgn_e                    rgn;
  logic [CIW-1:0]          ctl_idx;
  logic [SAW-1:0]          sram_idx;
  logic [TIME_N-1:0][7:0]  t_arr;
  logic [CTL_N-1:0][7:0]   c_arr;
  logic [7:0]              s_rd, rd_byte;

  assign stb      = dat_valid && !addr_valid;
  assign wr_stb   = stb && dat_wr;
  assign rd_stb   = stb && !dat_wr;
  assign rgn      = rgn_of(ptr, TIME_N, CTL_N, CLK_SPAN, SRAM_N);
  assign ctl_idx  = CIW'(ptr - 8'(TIME_N));
  assign sram_idx = SAW'(ptr - 8'(CLK_SPAN));

  rtc_addr_ptr #(.LIMIT(LIMIT)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_valid),
    .load_addr (addr_in),
    .step      (stb),
    .ptr       (ptr),
    .ack_vld   (addr_ack_vld),
    .ack       (addr_ack)
  );

  rtc_byte_regs #(.N(TIME_N)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_stb && (rgn == RGN_TIME)),
    .idx       (ptr[TIW-1:0]),
    .wdata     (dat_wdata),
    .upd_valid (tk_upd_valid),
    .upd_idx   (tk_upd_idx),
    .upd_data  (tk_upd_data),
    .q         (t_arr)
  );

  rtc_byte_regs #(.N(CTL_N)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_stb && (rgn == RGN_CTRL)),
    .idx       (ctl_idx),
    .wdata     (dat_wdata),
    .upd_valid (1'b0),
    .upd_idx   ('0),
    .upd_data  (8'h00),
    .q         (c_arr)
  );

  rtc_sram #(.DEPTH(SRAM_N)) u_sram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_stb && (rgn == RGN_SRAM)),
    .addr  (sram_idx),
    .wdata (dat_wdata),
    .rdata (s_rd)
  );

  assign time_bytes = t_arr;
  assign ctl_bytes  = c_arr;

  always_comb begin
    unique case (rgn)
      RGN_TIME: rd_byte = t_arr[ptr[TIW-1:0]];
      RGN_CTRL: rd_byte = c_arr[ctl_idx];
      RGN_SRAM: rd_byte = s_rd;
      default:  rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_rvalid <= 1'b0;
      dat_rdata  <= 8'h00;
    end else begin
      dat_rvalid <= rd_stb;
      if (rd_stb) dat_rdata <= rd_byte;
    end
  end

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
  parameter int TIME_N   = 7,
  parameter int CTL_N    = 16,
  parameter int CLK_SPAN = 32,
  parameter int SRAM_N   = 64,
  localparam int TIW = $clog2(TIME_N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                addr_valid,
  input logic [7:0]          addr_in,
  input logic                addr_ack_vld,
  input logic                addr_ack,
  input logic                dat_valid,
  input logic                dat_wr,
  input logic [7:0]          dat_wdata,
  input logic                dat_rvalid,
  input logic [7:0]          dat_rdata,
  input logic                tk_upd_valid,
  input logic [TIW-1:0]      tk_upd_idx,
  input logic [8*TIME_N-1:0] time_bytes,
  input logic [7:0]          ptr
);

  localparam logic [7:0] LIMIT   = 8'(CLK_SPAN + SRAM_N);
  localparam logic [7:0] RSV_LO  = 8'(TIME_N + CTL_N);
  localparam logic [7:0] CLK_TOP = 8'(CLK_SPAN);
  localparam logic [7:0] T_TOP   = 8'(TIME_N);

  logic           rd_stb;
  logic           zero_q, hit_q;
  logic [TIW-1:0] hit_idx;
  logic [7:0]     hit_dat, hit_sel;

  assign rd_stb  = dat_valid && !dat_wr && !addr_valid;
  assign hit_sel = time_bytes[8*hit_idx +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q  <= 1'b0;
      hit_q   <= 1'b0;
      hit_idx <= '0;
      hit_dat <= 8'h00;
    end else begin
      zero_q  <= rd_stb && (((ptr >= RSV_LO) && (ptr < CLK_TOP)) || (ptr >= LIMIT));
      hit_q   <= dat_valid && dat_wr && !addr_valid && (ptr < T_TOP) &&
                 tk_upd_valid && (tk_upd_idx == ptr[TIW-1:0]);
      hit_idx <= ptr[TIW-1:0];
      hit_dat <= dat_wdata;
    end
  end

  AST_ACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (addr_ack_vld && (addr_ack == ($past(addr_in) < LIMIT)))); // R1
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !addr_ack_vld); // R1
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> dat_rvalid); // R6
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !dat_rvalid); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !addr_valid && (ptr < LIMIT)) |=> (ptr == $past(ptr) + 8'd1)); // R7
  AST_PTR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr >= LIMIT) && !addr_valid) |=> $stable(ptr)); // R8
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> (dat_rdata == 8'h00)); // R4
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (hit_sel == hit_dat)); // R9

endmodule

bind rtc_regbank rtc_regbank_chk #(
  .TIME_N(TIME_N), .CTL_N(CTL_N), .CLK_SPAN(CLK_SPAN), .SRAM_N(SRAM_N)
) u_chk (.*);

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         addr_valid = 1'b0;
  logic [7:0]   addr_in = 8'h00;
  logic         addr_ack_vld, addr_ack;
  logic         dat_valid = 1'b0;
  logic         dat_wr = 1'b0;
  logic [7:0]   dat_wdata = 8'h00;
  logic         dat_rvalid;
  logic [7:0]   dat_rdata;
  logic         tk_upd_valid = 1'b0;
  logic [2:0]   tk_upd_idx = 3'd0;
  logic [7:0]   tk_upd_data = 8'h00;
  logic [55:0]  time_bytes;
  logic [127:0] ctl_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_regbank u_rtc_regbank (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  // Expected read value after the pattern burst.
  function automatic logic [7:0] expect_rd(input int a);
    if (a < 8'h17)      return pat(a);
    else if (a < 8'h20) return 8'h00;
    else if (a < 8'h60) return pat(a);
    else                return 8'h00;
  endfunction

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk);
    addr_valid = 1'b1; addr_in = a;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    dat_valid = 1'b1; dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_valid = 1'b0; dat_wr = 1'b0;
    check("R6 no rvalid after write", 128'(dat_rvalid), 128'(0));
  endtask

  task automatic rd_byte(input string req, input logic [7:0] exp);
    @(negedge clk);
    dat_valid = 1'b1; dat_wr = 1'b0;
    @(negedge clk);
    dat_valid = 1'b0;
    check("R6 rvalid after read", 128'(dat_rvalid), 128'(1));
    check(req, 128'(dat_rdata), 128'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: reset state
    check("R10 rvalid", 128'(dat_rvalid), 128'(0));
    check("R10 ack_vld", 128'(addr_ack_vld), 128'(0));
    check("R10 time_bytes", 128'(time_bytes), 128'(0));
    check("R10 ctl_bytes", ctl_bytes, 128'(0));
    set_addr(8'h00);
    for (int a = 0; a < 8'h60; a++) rd_byte("R10 cleared", 8'h00);

    // R1: acknowledge sweep over every address
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      addr_valid = 1'b1; addr_in = 8'(a);
      @(negedge clk);
      addr_valid = 1'b0;
      check("R1 ack_vld", 128'(addr_ack_vld), 128'(1));
      check("R1 ack", 128'(addr_ack), 128'(a < 8'h60));
      @(negedge clk);
      check("R1 pulse", 128'(addr_ack_vld), 128'(0));
    end

    // R7/R8: one burst writes the whole map and runs past the end
    set_addr(8'h00);
    for (int a = 0; a < 8'h63; a++) wr_byte(pat(a));
    check("R8 no extra ack", 128'(addr_ack_vld), 128'(0));
    for (int k = 0; k < 7; k++)
      check("R2 time_bytes", 128'(time_bytes[8*k +: 8]), 128'(pat(k)));
    for (int k = 0; k < 16; k++)
      check("R3 ctl_bytes", 128'(ctl_bytes[8*k +: 8]), 128'(pat(k + 7)));

    // Read back in one burst: R2 R3 R4 R5 R7 R8
    set_addr(8'h00);
    for (int a = 0; a < 8'h63; a++) begin
      if (a < 7)          rd_byte("R2 time readback", expect_rd(a));
      else if (a < 8'h17) rd_byte("R3 ctl readback", expect_rd(a));
      else if (a < 8'h20) rd_byte("R4 reserved zero", expect_rd(a));
      else if (a < 8'h60) rd_byte("R5 sram readback", expect_rd(a));
      else                rd_byte("R8 past end zero", expect_rd(a));
    end

    // R2: non-BCD value kept unchanged, random-access start address
    set_addr(8'h03);
    wr_byte(8'hFF);
    check("R2 verbatim", 128'(time_bytes[8*3 +: 8]), 128'(8'hFF));
    set_addr(8'h5F);
    rd_byte("R5 last sram", pat(8'h5F));
    rd_byte("R8 next zero", 8'h00);

    // R9: host write and calendar update in the same cycle
    for (int k = 0; k < 7; k++) begin
      set_addr(8'(k));
      @(negedge clk);
      dat_valid = 1'b1; dat_wr = 1'b1; dat_wdata = 8'hC0 | 8'(k);
      tk_upd_valid = 1'b1; tk_upd_idx = 3'(k); tk_upd_data = 8'h3C;
      @(negedge clk);
      dat_valid = 1'b0; dat_wr = 1'b0; tk_upd_valid = 1'b0;
      check("R9 host wins", 128'(time_bytes[8*k +: 8]), 128'(8'hC0 | 8'(k)));
    end
    for (int k = 0; k < 7; k++) begin
      int j;
      j = (k + 1) % 7;
      set_addr(8'(k));
      @(negedge clk);
      dat_valid = 1'b1; dat_wr = 1'b1; dat_wdata = 8'h50 + 8'(k);
      tk_upd_valid = 1'b1; tk_upd_idx = 3'(j); tk_upd_data = 8'hE0 + 8'(j);
      @(negedge clk);
      dat_valid = 1'b0; dat_wr = 1'b0; tk_upd_valid = 1'b0;
      check("R9 host byte", 128'(time_bytes[8*k +: 8]), 128'(8'h50 + 8'(k)));
      check("R9 update byte", 128'(time_bytes[8*j +: 8]), 128'(8'hE0 + 8'(j)));
    end
    @(negedge clk);
    tk_upd_valid = 1'b1; tk_upd_idx = 3'd2; tk_upd_data = 8'h99;
    @(negedge clk);
    tk_upd_valid = 1'b0;
    check("R9 update alone", 128'(time_bytes[8*2 +: 8]), 128'(8'h99));
    set_addr(8'h02);
    rd_byte("R9 update readable", 8'h99);

    // R4: write into a reserved hole, then read it
    set_addr(8'h1A);
    wr_byte(8'hA7);
    set_addr(8'h1A);
    rd_byte("R4 reserved write dropped", 8'h00);

    // R10: reset clears everything again
    do_reset();
    check("R10 time after reset", 128'(time_bytes), 128'(0));
    check("R10 ctl after reset", ctl_bytes, 128'(0));
    set_addr(8'h20);
    for (int a = 8'h20; a < 8'h60; a++) rd_byte("R10 sram after reset", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule